// File: doc/BRIEF.md
# Byte-Stream Memory Peek/Poke Bridge

This block lets a host reach a 32-bit local memory bus through nothing more than a byte-wide stream. Every host access arrives as a framed command. A single opcode byte comes first: 0x00 selects a write and 0x01 selects a read. Four address bytes follow. A write then carries four data bytes. The bridge assembles the fields, issues one request on the memory bus, and holds it until the memory acknowledges. For a read, it then sends the returned word back to the host on an outgoing byte stream.

Both streams use a valid/ready handshake. The input side stops accepting bytes while an access or a read reply is in progress. The output side holds each reply byte until the consumer takes it. Any opcode byte other than 0x00 or 0x01 is dropped and sets a sticky error flag, which only a reset clears.

The controller is a five-state machine:
- ST_OPCODE waits for the opcode byte.
- ST_ADDR gathers the address bytes.
- ST_DATA gathers the write data bytes.
- ST_ACCESS holds the memory request.
- ST_REPLY streams the read word out.

Its transitions are as follows:
- ST_OPCODE goes to ST_ADDR on a valid opcode.
- ST_ADDR goes to ST_DATA on the last address byte of a write.
- ST_ADDR goes to ST_ACCESS on the last address byte of a read.
- ST_DATA goes to ST_ACCESS on the last data byte.
- ST_ACCESS goes to ST_OPCODE on acknowledge of a write.
- ST_ACCESS goes to ST_REPLY on acknowledge of a read.
- ST_REPLY goes to ST_OPCODE once the last reply byte is taken.
- An unknown opcode keeps the machine in ST_OPCODE.
- Reset forces ST_OPCODE from any state.

Top module: `peekpoke_bridge`

## Requirements
- R1: An opcode byte 0x00 followed by four address bytes and four data bytes, each field least-significant byte first, produces one memory request with mem_we=1, mem_addr equal to the assembled address and mem_wdata equal to the assembled data.
- R2: An opcode byte 0x01 followed by four address bytes (least-significant first) produces one memory request with mem_we=0 and mem_addr equal to the assembled address. No data bytes are taken from the input stream for a read.
- R3: After a read is acknowledged, the bridge emits the four bytes of the mem_rdata value captured at the acknowledge, least-significant byte first, with out_valid high from the cycle after the acknowledge.
- R4: mem_req rises in the cycle after the last byte of a command is accepted. While mem_ack is low, mem_req stays high and mem_addr, mem_we and mem_wdata stay stable. mem_req is low in the cycle after the acknowledge.
- R5: in_ready is high while waiting for an opcode and while gathering fields. It is low from the cycle after the last command byte until the access completes and, for a read, until the last reply byte is accepted.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R7: An opcode byte other than 0x00 or 0x01 is consumed without any memory request and sets err_flag, which stays set until reset. The parser then accepts the next opcode normally.
- R8: A synchronous reset (rst high at a clock edge) returns the parser to opcode wait and discards partially received fields. It drops mem_req, clears out_valid and clears err_flag.
- R9: Bytes are consumed only in cycles where in_valid and in_ready are both high. Idle cycles between command bytes do not change the resulting access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Incoming command byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Bridge accepts an incoming byte |
| out_data | output | 8 | Outgoing reply byte |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Consumer accepts the reply byte |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| err_flag | output | 1 | Sticky flag for an unknown opcode |

## Verification
A wrong field counter or byte lane shows up on the first command as a rotated or mixed-up mem_addr or mem_wdata, in the same cycle mem_req rises. A wrong state shows within one cycle in other ways: mem_req rising too early or too late, in_ready staying high during an access, or the reply count being off so that in_ready returns while bytes are still owed. Reset taken in the middle of a command is checked by the address of the next full command. Stale counter state would shift every byte of that address.

// File: rtl/peekpoke_pkg.sv
package peekpoke_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h00;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h01;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_ACCESS,
        ST_REPLY
    } pp_state_e;

endpackage

// File: rtl/pp_field_collect.sv
// Gathers BYTES bytes, least-significant first, into one word.
module pp_field_collect #(
    parameter int BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         load,
    input  logic [peekpoke_pkg::BYTE_W-1:0] byte_in,
    output logic [BYTES*peekpoke_pkg::BYTE_W-1:0] word,
    output logic                         last
);
    localparam int BW = peekpoke_pkg::BYTE_W;
    localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [CW-1:0] idx_q;

    assign last = (idx_q == CW'(BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= last ? '0 : idx_q + CW'(1);
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                word[g*BW +: BW] <= '0;
            end else if (load && (idx_q == CW'(g))) begin
                word[g*BW +: BW] <= byte_in;
            end
        end
    end

endmodule

// File: rtl/pp_reply_ser.sv
// Emits a captured word as BYTES bytes, least-significant first.
module pp_reply_ser #(
    parameter int BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [BYTES*peekpoke_pkg::BYTE_W-1:0] word_in,
    input  logic                         advance,
    output logic [peekpoke_pkg::BYTE_W-1:0] byte_out,
    output logic                         last
);
    localparam int BW = peekpoke_pkg::BYTE_W;
    localparam int W  = BYTES * BW;
    localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [W-1:0]  shift_q;
    logic [CW-1:0] idx_q;

    assign byte_out = shift_q[BW-1:0];
    assign last     = (idx_q == CW'(BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            shift_q <= word_in;
            idx_q   <= '0;
        end else if (advance) begin
            shift_q <= shift_q >> BW;
            idx_q   <= last ? '0 : idx_q + CW'(1);
        end
    end

endmodule

// File: rtl/peekpoke_bridge.sv
module peekpoke_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              err_flag
);
    import peekpoke_pkg::*;

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;

    pp_state_e state_q, state_d;
    logic      is_read_q;
    logic      err_q;
    logic      in_fire, out_fire;
    logic      op_valid;
    logic      addr_last, data_last, reply_last;
    logic      addr_load, data_load, field_clr, reply_load;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign op_valid = (in_data == OP_WRITE) || (in_data == OP_READ);

    assign field_clr  = in_fire && (state_q == ST_OPCODE);
    assign addr_load  = in_fire && (state_q == ST_ADDR);
    assign data_load  = in_fire && (state_q == ST_DATA);
    assign reply_load = (state_q == ST_ACCESS) && mem_ack && is_read_q;

    pp_field_collect #(.BYTES(ADDR_BYTES)) addr_col_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (field_clr),
        .load    (addr_load),
        .byte_in (in_data),
        .word    (mem_addr),
        .last    (addr_last)
    );

    pp_field_collect #(.BYTES(DATA_BYTES)) data_col_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (field_clr),
        .load    (data_load),
        .byte_in (in_data),
        .word    (mem_wdata),
        .last    (data_last)
    );

    pp_reply_ser #(.BYTES(DATA_BYTES)) reply_i (
        .clk      (clk),
        .rst      (rst),
        .load     (reply_load),
        .word_in  (mem_rdata),
        .advance  (out_fire),
        .byte_out (out_data),
        .last     (reply_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPCODE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command kind and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            is_read_q <= 1'b0;
            err_q     <= 1'b0;
        end else if (field_clr) begin
            if (op_valid) begin
                is_read_q <= (in_data == OP_READ);
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: begin
                if (in_fire && op_valid) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (in_fire && addr_last) state_d = is_read_q ? ST_ACCESS : ST_DATA;
            end
            ST_DATA: begin
                if (in_fire && data_last) state_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (mem_ack) state_d = is_read_q ? ST_REPLY : ST_OPCODE;
            end
            ST_REPLY: begin
                if (out_fire && reply_last) state_d = ST_OPCODE;
            end
            default: state_d = ST_OPCODE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_OPCODE, ST_ADDR, ST_DATA: in_ready  = 1'b1;
            ST_ACCESS:                   mem_req   = 1'b1;
            ST_REPLY:                    out_valid = 1'b1;
            default: ;
        endcase
    end

    assign mem_we   = !is_read_q;
    assign err_flag = err_q;

endmodule

// File: rtl/peekpoke_bridge_chk.sv
module peekpoke_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic [7:0]        out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              err_flag
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req);  // R4
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));  // R4
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req);  // R4
    AST_NO_INPUT_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_ready);  // R5
    AST_NO_INPUT_IN_REPLY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);  // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));  // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);  // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> in_ready && !mem_req && !out_valid && !err_flag);  // R8
endmodule

bind peekpoke_bridge peekpoke_bridge_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .err_flag  (err_flag)
);

// File: tb/peekpoke_bridge_tb_top.sv
`timescale 1ns/1ps
module peekpoke_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        err_flag;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    peekpoke_bridge dut_i (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .err_flag(err_flag)
    );

    typedef struct packed {
        logic        rd;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic [3:0]  gap;
        logic [3:0]  ack_dly;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0,          4'd0, 4'd0},
        '{1'b1, 32'h0000_0010, 32'h0,          32'hA5C3_0F81, 4'd0, 4'd2},
        '{1'b0, 32'hFFFF_FFFC, 32'h0000_0001, 32'h0,          4'd3, 4'd1},
        '{1'b1, 32'h8000_0000, 32'h0,          32'h0102_0304, 4'd2, 4'd0},
        '{1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0,          4'd1, 4'd4},
        '{1'b1, 32'hCAFE_F00D, 32'h0,          32'hFF00_FF00, 4'd1, 4'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one byte after gap idle cycles; return at the negedge after acceptance.
    task automatic send_byte(input logic [7:0] b, input int gap);
        for (int k = 0; k < gap; k++) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        mem_ack = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cmd(input vec_t v);
        logic [7:0] held;
        send_byte(v.rd ? 8'h01 : 8'h00, int'(v.gap));
        for (int i = 0; i < 4; i++) send_byte(v.addr[8*i +: 8], int'(v.gap));
        if (!v.rd) begin
            for (int i = 0; i < 4; i++) send_byte(v.wdata[8*i +: 8], int'(v.gap));
        end
        chk("R4 req after last byte", {31'd0, mem_req}, 32'd1);
        chk(v.rd ? "R2 read addr" : "R1 write addr", mem_addr, v.addr);
        chk(v.rd ? "R2 we low" : "R1 we high", {31'd0, mem_we}, {31'd0, !v.rd});
        if (!v.rd) chk("R1 write data", mem_wdata, v.wdata);
        chk("R5 ready low in access", {31'd0, in_ready}, 32'd0);
        for (int k = 0; k < int'(v.ack_dly); k++) begin
            @(negedge clk);
            chk("R4 req held", {31'd0, mem_req}, 32'd1);
            chk("R4 addr stable", mem_addr, v.addr);
        end
        mem_ack   = 1'b1;
        mem_rdata = v.rdata;
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = 32'h5555_5555;
        chk("R4 req dropped", {31'd0, mem_req}, 32'd0);
        if (v.rd) begin
            for (int i = 0; i < 4; i++) begin
                chk("R3 out valid", {31'd0, out_valid}, 32'd1);
                chk("R3 reply byte", {24'd0, out_data}, {24'd0, v.rdata[8*i +: 8]});
                chk("R5 ready low in reply", {31'd0, in_ready}, 32'd0);
                if (i == 1) begin
                    held = out_data;
                    @(negedge clk);
                    chk("R6 valid held", {31'd0, out_valid}, 32'd1);
                    chk("R6 data held", {24'd0, out_data}, {24'd0, held});
                end
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
            chk("R3 reply ends", {31'd0, out_valid}, 32'd0);
        end
        chk("R5 ready back", {31'd0, in_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 reset ready", {31'd0, in_ready}, 32'd1);
        chk("R8 reset req", {31'd0, mem_req}, 32'd0);
        chk("R8 reset out", {31'd0, out_valid}, 32'd0);
        chk("R8 reset err", {31'd0, err_flag}, 32'd0);

        // R1 R2 R3 R9: vector table
        for (int n = 0; n < NVEC; n++) run_cmd(VECS[n]);

        // R7: unknown opcode ignored, flag sticky, next command normal
        send_byte(8'h5A, 0);
        chk("R7 no request", {31'd0, mem_req}, 32'd0);
        chk("R7 err set", {31'd0, err_flag}, 32'd1);
        chk("R7 still ready", {31'd0, in_ready}, 32'd1);
        send_byte(8'h02, 0);
        send_byte(8'hFF, 0);
        chk("R7 no request after more", {31'd0, mem_req}, 32'd0);
        run_cmd('{1'b0, 32'h0BAD_F00D, 32'h7654_3210, 32'h0, 4'd0, 4'd1});
        chk("R7 err sticky", {31'd0, err_flag}, 32'd1);

        // R8: reset clears error flag
        pulse_reset();
        chk("R8 err cleared", {31'd0, err_flag}, 32'd0);

        // R8: reset mid-command discards partial address
        send_byte(8'h00, 0);
        send_byte(8'h11, 0);
        send_byte(8'h22, 0);
        pulse_reset();
        chk("R8 ready after partial", {31'd0, in_ready}, 32'd1);
        run_cmd('{1'b0, 32'h0000_0044, 32'h0000_0005, 32'h0, 4'd0, 4'd0});

        // R8: reset during an access drops the request
        send_byte(8'h01, 0);
        for (int i = 0; i < 4; i++) send_byte(8'h30 + 8'(i), 0);
        chk("R8 req before reset", {31'd0, mem_req}, 32'd1);
        pulse_reset();
        chk("R8 req dropped", {31'd0, mem_req}, 32'd0);
        chk("R8 out idle", {31'd0, out_valid}, 32'd0);
        run_cmd('{1'b1, 32'h0000_0100, 32'h0, 32'h8899_AABB, 4'd0, 4'd0});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule